// File: doc/BRIEF.md
# Register-Mapped Factorial Engine

This block is a 32-bit register slave that computes a factorial in the background. Software writes an operand to the operand register and the block starts an iterative computation, one multiply per clock. While it runs, a busy flag is set in the status word. When the computation finishes, the truncated product replaces the operand in the same register and the busy flag clears.

Software can find out that the result is ready in two ways. It can poll the busy flag. It can also set an enable bit in the status word, and the block then emits a one-cycle completion event toward an interrupt status block. The register window also holds a fixed identification word and a scratch register that stores the bitwise complement of whatever is written to it.

Accesses in the low part of the window (offsets below 0x80) must be full 32-bit words. The register bus is a plain address / write-enable / write-data / size interface. Read data is registered and appears one clock after the address is presented.

Top module: `fact_accel`

## Requirements
- R1: A word read (size code 2'b10) of offset 0x00 returns the constant 0x010000ED. Writes to that offset change nothing.
- R2: A word write to offset 0x04 stores the bitwise complement of the written data. A word read of 0x04 returns the stored value.
- R3: A word write to offset 0x08 while idle loads the operand and sets the busy flag, which is bit 0 of the status word at offset 0x20. A read of 0x08 presented in the cycle after the write returns the operand, for operands of 1 or more.
- R4: A write to offset 0x08 while busy is ignored. The result is the factorial of the operand that was accepted first.
- R5: On completion, offset 0x08 holds n·(n−1)·…·1 truncated to 32 bits, with operand 0 giving 1. The busy flag clears max(n−1,1) clocks after the clock edge that accepted the operand.
- R6: Status bit 7 (mask 0x80) is a read/write completion-event enable. Bit 0 cannot be written. All other status bits read as zero.
- R7: When a computation finishes with the enable bit set, `done_evt` is high for exactly one cycle. It rises on the same edge on which busy falls. With the enable bit clear it stays low.
- R8: The size code 2'b10 means a 4-byte access. For offsets below 0x80, any other size code makes a write have no effect and makes a read return 0xFFFFFFFF.
- R9: Word reads of offsets without a register (including all offsets at or above 0x80) return zero. Writes to those offsets change nothing.
- R10: A synchronous active-high reset clears the scratch register, the operand/result register, the enable bit, the busy flag, the read data and the event output.
- R11: Read data is registered. `bus_rdata` reflects the access presented in the previous cycle, sampled before that cycle's own write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (20) | Byte offset of the access |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_size | input | 2 | Access size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| done_evt | output | 1 | One-cycle completion event (interrupt cause bit 0) |

## Verification
Read data is due one clock after the address is presented. The driver therefore stamps every expected read value with the cycle count of the edge that captures it, and the monitor compares only at the negative edge where that stamp matches. The completion event is due max(n−1,1) clocks after the accepting edge. The bench counts negative edges from the write until `done_evt` goes high and compares that count with the value computed from the operand. It then checks that the pulse is gone on the following edge. Results at offset 0x08 are read only after a wait longer than the computed latency, against a factorial that the bench computes itself in 32-bit arithmetic.

// File: rtl/fact_pkg.sv
package fact_pkg;

  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_SCR   = 8'h04;
  localparam logic [7:0] OFS_OPR   = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h20;
  localparam logic [7:0] OFS_LIMIT = 8'h80;

  localparam logic [31:0] ID_WORD = 32'h010000ED;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IEN_BIT  = 7;

  // access size code: log2 of the byte count
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_SCR,
    SEL_OPR,
    SEL_STAT,
    SEL_BAD
  } rsel_e;

endpackage

// File: rtl/fact_bus_dec.sv
module fact_bus_dec
  import fact_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  output rsel_e             rsel_o,
  output logic              wr_scr_o,
  output logic              wr_opr_o,
  output logic              wr_stat_o
);

  logic low_win;
  logic size_ok;
  logic acc_ok;

  assign low_win = (addr_i < ADDR_W'(OFS_LIMIT));
  assign size_ok = (size_i == SZ_WORD);
  assign acc_ok  = low_win && size_ok;

  always_comb begin
    rsel_o = SEL_NONE;
    if (low_win && !size_ok) begin
      rsel_o = SEL_BAD;
    end else if (acc_ok) begin
      if (addr_i == ADDR_W'(OFS_ID))        rsel_o = SEL_ID;
      else if (addr_i == ADDR_W'(OFS_SCR))  rsel_o = SEL_SCR;
      else if (addr_i == ADDR_W'(OFS_OPR))  rsel_o = SEL_OPR;
      else if (addr_i == ADDR_W'(OFS_STAT)) rsel_o = SEL_STAT;
    end
  end

  assign wr_scr_o  = wr_i && acc_ok && (addr_i == ADDR_W'(OFS_SCR));
  assign wr_opr_o  = wr_i && acc_ok && (addr_i == ADDR_W'(OFS_OPR));
  assign wr_stat_o = wr_i && acc_ok && (addr_i == ADDR_W'(OFS_STAT));

endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] value_o,
  output logic              finish_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              busy_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] prod;
  logic              last_step;

  assign prod      = acc_q * cnt_q;
  assign last_step = (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        acc_q  <= (operand_i == '0) ? ONE : operand_i;
        cnt_q  <= (operand_i <= ONE) ? '0 : operand_i - ONE;
      end
    end else if (last_step) begin
      busy_q <= 1'b0;
    end else begin
      acc_q <= prod;
      cnt_q <= cnt_q - ONE;
    end
  end

  assign busy_o   = busy_q;
  assign value_o  = acc_q;
  assign finish_o = busy_q && last_step;

  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> (busy_q && value_o == (($past(operand_i) == '0) ? ONE : $past(operand_i))));

  // R4
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_q && !last_step) |=> (cnt_q == $past(cnt_q) - ONE));

  // R5
  finish_hold_chk: assert property (@(posedge clk) disable iff (rst)
    finish_o |=> (!busy_o && $stable(value_o)));

endmodule

// File: rtl/fact_regs.sv
module fact_regs
  import fact_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  rsel_e             rsel_i,
  input  logic              wr_scr_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              finish_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              evt_o
);

  logic [DATA_W-1:0] scratch_q;
  logic              irq_en_q;
  logic [DATA_W-1:0] rdata_q;
  logic              evt_q;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_BUSY_BIT] = busy_i;
    stat_word[STAT_IEN_BIT]  = irq_en_q;
  end

  always_comb begin
    unique case (rsel_i)
      SEL_ID:   rd_next = DATA_W'(ID_WORD);
      SEL_SCR:  rd_next = scratch_q;
      SEL_OPR:  rd_next = value_i;
      SEL_STAT: rd_next = stat_word;
      SEL_BAD:  rd_next = '1;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      irq_en_q  <= 1'b0;
      rdata_q   <= '0;
      evt_q     <= 1'b0;
    end else begin
      if (wr_scr_i)  scratch_q <= ~wdata_i;
      if (wr_stat_i) irq_en_q  <= wdata_i[STAT_IEN_BIT];
      rdata_q <= rd_next;
      evt_q   <= finish_i && irq_en_q;
    end
  end

  assign rdata_o = rdata_q;
  assign evt_o   = evt_q;

  // R1
  id_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel_i == SEL_ID) |=> (rdata_o == DATA_W'(ID_WORD)));

  // R2
  scratch_inv_chk: assert property (@(posedge clk) disable iff (rst)
    wr_scr_i |=> (scratch_q == ~$past(wdata_i)));

  // R6
  busy_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel_i == SEL_STAT) |=> (rdata_o[STAT_BUSY_BIT] == $past(busy_i)));

  // R7
  evt_cause_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> $past(finish_i && irq_en_q));

  // R8
  bad_size_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel_i == SEL_BAD) |=> (&rdata_o));

endmodule

// File: rtl/fact_accel.sv
module fact_accel
  import fact_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              done_evt
);

  rsel_e             rsel;
  logic              wr_scr;
  logic              wr_opr;
  logic              wr_stat;
  logic              busy;
  logic [DATA_W-1:0] value;
  logic              finish;

  fact_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (bus_addr),
    .wr_i      (bus_wr),
    .size_i    (bus_size),
    .rsel_o    (rsel),
    .wr_scr_o  (wr_scr),
    .wr_opr_o  (wr_opr),
    .wr_stat_o (wr_stat)
  );

  fact_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start_i   (wr_opr),
    .operand_i (bus_wdata),
    .busy_o    (busy),
    .value_o   (value),
    .finish_o  (finish)
  );

  fact_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rsel_i    (rsel),
    .wr_scr_i  (wr_scr),
    .wr_stat_i (wr_stat),
    .wdata_i   (bus_wdata),
    .busy_i    (busy),
    .value_i   (value),
    .finish_i  (finish),
    .rdata_o   (bus_rdata),
    .evt_o     (done_evt)
  );

  // R7
  evt_with_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done_evt |-> $fell(busy));

  // R7
  evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> !done_evt);

endmodule

// File: tb/tb_fact_accel.sv
module tb_fact_accel;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr;
  logic [DATA_W-1:0] bus_wdata;
  logic [1:0]        bus_size;
  logic [DATA_W-1:0] bus_rdata;
  logic              done_evt;

  fact_accel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .done_evt  (done_evt)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops an expectation when its capture edge has passed
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_tests++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: read actual %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (!finished && cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] fact_ref(input logic [31:0] n);
    logic [31:0] f;
    f = 32'd1;
    for (int i = 2; i <= int'(n); i++) f = f * 32'(i);
    return f;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: present a read and push its expectation (captured at next edge)
  task automatic rd(input logic [19:0] a, input logic [1:0] sz,
                    input logic [31:0] exp, input string tag);
    item_t it;
    bus_addr = a;
    bus_size = sz;
    bus_wr   = 1'b0;
    it.exp = exp;
    it.due = cyc + 1;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [1:0] sz);
    bus_addr  = a;
    bus_wdata = d;
    bus_size  = sz;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    bus_addr = 20'h0_0010;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // start a computation and measure the event latency (R5, R7)
  task automatic run_evt(input logic [31:0] n);
    int k;
    int lat;
    lat = (n <= 1) ? 1 : int'(n) - 1;
    wr(20'h08, n, 2'b10);
    bus_addr = 20'h0_0010;
    k = 1;
    while (!done_evt && k < lat + 20) begin
      @(negedge clk);
      k++;
    end
    chk("R5 R7 event cycle", 32'(k), 32'(lat + 1));
    @(negedge clk);
    chk("R7 single-cycle pulse", {31'd0, done_evt}, 32'd0);
  endtask

  initial begin
    rst       = 1'b1;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    bus_size  = 2'b10;
    repeat (4) @(negedge clk);
    chk("R10 rdata after reset", bus_rdata, 32'd0);
    chk("R10 event after reset", {31'd0, done_evt}, 32'd0);
    rst = 1'b0;

    rd(20'h04, 2'b10, 32'd0, "R10 scratch cleared");
    rd(20'h08, 2'b10, 32'd0, "R10 operand cleared");
    rd(20'h20, 2'b10, 32'd0, "R10 status cleared");

    // identification and size rules
    rd(20'h00, 2'b10, 32'h010000ED, "R1 R11 id word");
    wr(20'h00, 32'h0, 2'b10);
    rd(20'h00, 2'b10, 32'h010000ED, "R1 id after write");
    rd(20'h00, 2'b00, 32'hFFFFFFFF, "R8 byte read ones");
    rd(20'h04, 2'b11, 32'hFFFFFFFF, "R8 dword read ones");

    // scratch
    wr(20'h04, 32'h12345678, 2'b10);
    rd(20'h04, 2'b10, 32'hEDCBA987, "R2 scratch inverse");
    wr(20'h04, 32'hFFFF0000, 2'b01);
    rd(20'h04, 2'b10, 32'hEDCBA987, "R8 bad-size write ignored");
    wr(20'h04, 32'h0, 2'b10);
    rd(20'h04, 2'b10, 32'hFFFFFFFF, "R2 scratch of zero");

    // unmapped
    rd(20'h10, 2'b10, 32'd0, "R9 unmapped low");
    rd(20'h80, 2'b10, 32'd0, "R9 high offset");
    rd(20'h98, 2'b11, 32'd0, "R9 high offset dword");
    wr(20'h88, 32'h5, 2'b10);
    rd(20'h20, 2'b10, 32'd0, "R9 high write no start");

    // status bits
    wr(20'h20, 32'hFFFFFFFF, 2'b10);
    rd(20'h20, 2'b10, 32'h00000080, "R6 enable set busy untouched");
    wr(20'h20, 32'h0, 2'b10);
    rd(20'h20, 2'b10, 32'd0, "R6 enable cleared");

    // start, busy, result
    wr(20'h08, 32'd9, 2'b10);
    rd(20'h08, 2'b10, 32'd9, "R3 operand readback");
    rd(20'h20, 2'b10, 32'h1, "R3 busy set");
    idle(12);
    rd(20'h08, 2'b10, fact_ref(32'd9), "R5 result 9");
    rd(20'h20, 2'b10, 32'd0, "R5 busy clear");

    wr(20'h08, 32'd0, 2'b10);
    idle(4);
    rd(20'h08, 2'b10, 32'd1, "R5 zero gives one");
    wr(20'h08, 32'd1, 2'b10);
    idle(4);
    rd(20'h08, 2'b10, 32'd1, "R5 one gives one");
    wr(20'h08, 32'd13, 2'b10);
    idle(16);
    rd(20'h08, 2'b10, fact_ref(32'd13), "R5 truncated 13");
    wr(20'h08, 32'd12, 2'b10);
    idle(16);
    rd(20'h08, 2'b10, 32'd479001600, "R5 result 12");

    // write while busy
    wr(20'h08, 32'd6, 2'b10);
    wr(20'h08, 32'd3, 2'b10);
    idle(10);
    rd(20'h08, 2'b10, fact_ref(32'd6), "R4 busy write ignored");

    // bad-size operand write
    wr(20'h08, 32'd4, 2'b11);
    rd(20'h20, 2'b10, 32'd0, "R8 bad-size no start");
    rd(20'h08, 2'b10, fact_ref(32'd6), "R8 operand unchanged");

    // event path
    wr(20'h20, 32'h80, 2'b10);
    run_evt(32'd7);
    rd(20'h08, 2'b10, fact_ref(32'd7), "R5 result 7");
    run_evt(32'd2);
    run_evt(32'd0);
    wr(20'h20, 32'h0, 2'b10);
    wr(20'h08, 32'd4, 2'b10);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 10; i++) begin
        if (done_evt) seen++;
        @(negedge clk);
      end
      chk("R7 no event when disabled", 32'(seen), 32'd0);
    end
    rd(20'h08, 2'b10, 32'd24, "R5 result 4");

    idle(3);
    chk("R11 queue drained", 32'(q.size()), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule